// File: doc/BRIEF.md
# Standby STOP-Mode Entry Controller

This block decides when a microcontroller enters its deepest low-power state and drives the clock-gate and pad-control outputs that go with it. Software requests the state by writing a control byte with the stop bit set, using a dedicated full-byte write access. If an enabled interrupt is already pending at that moment, the request is dropped: the byte is stored with the stop bit cleared and the core keeps running.

Once stopped, the oscillator is disabled and the system clock is gated. The control and strobe pads are released to high impedance, and the multiplexed low address/data byte floats. The upper address lines are forced low. If the external-clock option is clear, a clamp ties the oscillator input to ground. A pending interrupt wakes the block. It first re-enables the oscillator and then waits a programmable settling count before it ungates the clock and returns every pad control to its run value in the same cycle.

The oscillator-option byte carries the external-clock select and a settling-count selector. An A/D enable status input is reported as a leakage warning flag for as long as the clock is stopped.

Top module: `stby_stop_ctl`

## Requirements
- R1: After a synchronous active-low reset, the block is in run: osc_en=1, sysclk_en=1, strobe_oe=1, ad_oe all ones, addr_hi_low all zeros, osc_clamp=0, adc_leak=0, mode_q=8'h00, with the external-clock select and settling selector both cleared.
- R2: A write with ctl_wr_en=1 and ctl_wr_kind=1 in run, with ctl_wdata bit 0 (the stop bit) set and irq_pending=0, stores the byte in mode_q. From the next cycle the block is stopped, with osc_en=0 and sysclk_en=0.
- R3: The same write made while irq_pending=1 leaves the block in run and stores the byte with bit 0 forced to 0.
- R4: A write with ctl_wr_kind=0 (any access other than the dedicated full-byte write) leaves mode_q and the run state unchanged.
- R5: While osc_en=0 or sysclk_en=0 after entry, strobe_oe=0, every ad_oe bit is 0 and every addr_hi_low bit is 1.
- R6: osc_clamp is 1 only while stopped with the external-clock select (bit 7 of the oscillator-option byte) at 0. It stays 0 when that bit is 1 and during settling.
- R7: adc_leak equals adc_en whenever sysclk_en=0, and is 0 in run.
- R8: irq_pending=1 while stopped sets osc_en=1 on the next cycle. sysclk_en then stays 0 for 2^(sel+STAB_BASE) cycles, where sel is bits 2:0 of the oscillator-option byte. After that, sysclk_en, strobe_oe, ad_oe and addr_hi_low return to run values in the same cycle.
- R9: On that return to run, mode_q bit 0 is cleared and bits 7:1 are kept.
- R10: Writes to either register are ignored while sysclk_en=0.
- R11: Reset taken while stopped returns the block to the R1 state on the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Always-running control clock |
| rst_n | input | 1 | Synchronous active-low reset |
| ctl_wr_en | input | 1 | Write strobe for the standby control byte |
| ctl_wr_kind | input | 1 | 1 = dedicated full-byte write, 0 = any other access |
| ctl_wdata | input | 8 | Control byte; bit 0 requests stop |
| osc_wr_en | input | 1 | Write strobe for the oscillator-option byte |
| osc_wdata | input | 8 | Bit 7 external-clock select, bits 2:0 settling selector |
| irq_pending | input | 1 | A pending, enabled interrupt exists |
| adc_en | input | 1 | A/D converter enable status |
| mode_q | output | 8 | Stored standby control byte |
| osc_en | output | 1 | Oscillator enable |
| sysclk_en | output | 1 | System clock gate enable |
| strobe_oe | output | 1 | Drive enable for read, write, address-strobe and refresh pads |
| ad_oe | output | 8 | Drive enables for the multiplexed low address/data byte |
| addr_hi_low | output | 12 | Force-low requests for the upper address lines |
| osc_clamp | output | 1 | Request to tie the oscillator input to ground |
| adc_leak | output | 1 | Converter left enabled while the clock is stopped |

## Verification
The assertions assume that irq_pending is the only wake source and that no register write is seen as meaningful while the clock is gated. They also assume that write strobes last one cycle and never coincide with reset. The stimulus raises the strobes for exactly one cycle, drives them only in run except when testing R10, and holds irq_pending low during entry except when testing cancellation. This keeps every transition in the sequence run, stop, settle, run.

// File: rtl/stby_pkg.sv
// Shared types and field positions for the standby STOP controller.
// Assumes an 8-bit control byte and an 8-bit oscillator-option byte.
package stby_pkg;
    typedef enum logic [1:0] {
        ST_RUN  = 2'd0,
        ST_STOP = 2'd1,
        ST_WARM = 2'd2
    } stby_state_e;

    localparam int STP_BIT = 0;  // stop request bit in the control byte
    localparam int EXT_BIT = 7;  // external-clock select in the option byte
endpackage

// File: rtl/stby_regs.sv
// Holds the standby control byte and the oscillator options.
// Accepts writes only in run; only the dedicated full-byte access may
// touch the control byte. Drops the stop bit when an interrupt is pending.
// Clears the stop bit when the sequencer finishes settling.
module stby_regs
    import stby_pkg::*;
#(
    parameter int SEL_W = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run,
    input  logic             wake_done,
    input  logic             ctl_wr_en,
    input  logic             ctl_wr_kind,
    input  logic [7:0]       ctl_wdata,
    input  logic             osc_wr_en,
    input  logic [7:0]       osc_wdata,
    input  logic             irq_pending,
    output logic [7:0]       mode_q,
    output logic             ext_clk,
    output logic [SEL_W-1:0] stab_sel,
    output logic             enter_stop
);
    logic       ctl_take;
    logic [7:0] ctl_masked;

    // Qualify a control write: run state and the dedicated access only.
    assign ctl_take   = run && ctl_wr_en && ctl_wr_kind;
    assign enter_stop = ctl_take && ctl_wdata[STP_BIT] && !irq_pending;

    // Discard the stop request when an interrupt is already pending.
    always_comb begin
        ctl_masked          = ctl_wdata;
        ctl_masked[STP_BIT] = ctl_wdata[STP_BIT] & ~irq_pending;
    end

    // Control byte storage with hardware clear of the stop bit on wake.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mode_q <= '0;
        end else if (ctl_take) begin
            mode_q <= ctl_masked;
        end else if (wake_done) begin
            mode_q[STP_BIT] <= 1'b0;
        end
    end

    // Oscillator option fields, written in run only.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ext_clk  <= 1'b0;
            stab_sel <= '0;
        end else if (run && osc_wr_en) begin
            ext_clk  <= osc_wdata[EXT_BIT];
            stab_sel <= osc_wdata[SEL_W-1:0];
        end
    end
endmodule

// File: rtl/stby_seq.sv
// Run/stop/settle sequencer with the oscillator settling counter.
// Assumes irq_pending is the only wake source; reset is handled synchronously.
// Settling lasts 2^(stab_sel+STAB_BASE) cycles.
module stby_seq
    import stby_pkg::*;
#(
    parameter int SEL_W     = 3,
    parameter int STAB_BASE = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             enter_stop,
    input  logic             irq_pending,
    input  logic [SEL_W-1:0] stab_sel,
    output stby_state_e      state,
    output logic             wake_done
);
    localparam int CNT_W = (1 << SEL_W) + STAB_BASE;

    logic [CNT_W-1:0] cnt;
    logic [CNT_W-1:0] load_val;

    // Settling length minus one, so the counter ends at zero.
    assign load_val  = (CNT_W'(1) << (CNT_W'(stab_sel) + CNT_W'(STAB_BASE))) - CNT_W'(1);
    assign wake_done = (state == ST_WARM) && (cnt == '0);

    // State transitions and settling count.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state <= ST_RUN;
            cnt   <= '0;
        end else begin
            unique case (state)
                ST_RUN: if (enter_stop) state <= ST_STOP;
                ST_STOP: if (irq_pending) begin
                    state <= ST_WARM;
                    cnt   <= load_val;
                end
                ST_WARM: if (cnt == '0) state <= ST_RUN;
                         else           cnt   <= cnt - CNT_W'(1);
                default: state <= ST_RUN;
            endcase
        end
    end
endmodule

// File: rtl/stby_pins.sv
// Decodes the sequencer state into clock-gate and pad-control outputs.
// Purely combinational; all outputs change together with the state.
module stby_pins
    import stby_pkg::*;
#(
    parameter int AD_W = 8,
    parameter int HI_W = 12
) (
    input  stby_state_e     state,
    input  logic            ext_clk,
    input  logic            adc_en,
    output logic            osc_en,
    output logic            sysclk_en,
    output logic            strobe_oe,
    output logic [AD_W-1:0] ad_oe,
    output logic [HI_W-1:0] addr_hi_low,
    output logic            osc_clamp,
    output logic            adc_leak
);
    logic run;

    // Clock controls and single-bit pad controls.
    always_comb begin
        run       = (state == ST_RUN);
        osc_en    = (state != ST_STOP);
        sysclk_en = run;
        strobe_oe = run;
        osc_clamp = (state == ST_STOP) && !ext_clk;
        adc_leak  = !run && adc_en;
    end

    // One drive enable or force-low per bus line.
    for (genvar i = 0; i < AD_W; i++) begin : g_ad
        assign ad_oe[i] = run;
    end
    for (genvar j = 0; j < HI_W; j++) begin : g_hi
        assign addr_hi_low[j] = !run;
    end
endmodule

// File: rtl/stby_stop_ctl.sv
// Top of the standby STOP-mode entry controller.
// Connects register storage, the sequencer and the pad-control decode.
// Assumes one write strobe per cycle and a free-running control clock.
module stby_stop_ctl
    import stby_pkg::*;
#(
    parameter int SEL_W     = 3,
    parameter int STAB_BASE = 2,
    parameter int AD_W      = 8,
    parameter int HI_W      = 12
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            ctl_wr_en,
    input  logic            ctl_wr_kind,
    input  logic [7:0]      ctl_wdata,
    input  logic            osc_wr_en,
    input  logic [7:0]      osc_wdata,
    input  logic            irq_pending,
    input  logic            adc_en,
    output logic [7:0]      mode_q,
    output logic            osc_en,
    output logic            sysclk_en,
    output logic            strobe_oe,
    output logic [AD_W-1:0] ad_oe,
    output logic [HI_W-1:0] addr_hi_low,
    output logic            osc_clamp,
    output logic            adc_leak
);
    stby_state_e      state;
    logic             wake_done;
    logic             enter_stop;
    logic             ext_clk;
    logic [SEL_W-1:0] stab_sel;

    stby_regs #(.SEL_W(SEL_W)) u_regs (
        .clk         (clk),
        .rst_n       (rst_n),
        .run         (state == ST_RUN),
        .wake_done   (wake_done),
        .ctl_wr_en   (ctl_wr_en),
        .ctl_wr_kind (ctl_wr_kind),
        .ctl_wdata   (ctl_wdata),
        .osc_wr_en   (osc_wr_en),
        .osc_wdata   (osc_wdata),
        .irq_pending (irq_pending),
        .mode_q      (mode_q),
        .ext_clk     (ext_clk),
        .stab_sel    (stab_sel),
        .enter_stop  (enter_stop)
    );

    stby_seq #(.SEL_W(SEL_W), .STAB_BASE(STAB_BASE)) u_seq (
        .clk         (clk),
        .rst_n       (rst_n),
        .enter_stop  (enter_stop),
        .irq_pending (irq_pending),
        .stab_sel    (stab_sel),
        .state       (state),
        .wake_done   (wake_done)
    );

    stby_pins #(.AD_W(AD_W), .HI_W(HI_W)) u_pins (
        .state       (state),
        .ext_clk     (ext_clk),
        .adc_en      (adc_en),
        .osc_en      (osc_en),
        .sysclk_en   (sysclk_en),
        .strobe_oe   (strobe_oe),
        .ad_oe       (ad_oe),
        .addr_hi_low (addr_hi_low),
        .osc_clamp   (osc_clamp),
        .adc_leak    (adc_leak)
    );
endmodule

// File: rtl/stby_stop_ctl_chk.sv
// Port-level protocol checker for stby_stop_ctl, attached by bind.
// Assumes irq_pending is the only wake source.
module stby_stop_ctl_chk #(
    parameter int AD_W = 8,
    parameter int HI_W = 12
) (
    input logic            clk,
    input logic            rst_n,
    input logic            ctl_wr_en,
    input logic            ctl_wr_kind,
    input logic [7:0]      ctl_wdata,
    input logic            irq_pending,
    input logic [7:0]      mode_q,
    input logic            osc_en,
    input logic            sysclk_en,
    input logic            strobe_oe,
    input logic [AD_W-1:0] ad_oe,
    input logic [HI_W-1:0] addr_hi_low,
    input logic            osc_clamp,
    input logic            adc_leak
);
    AST_STOP_ENTRY: assert property (@(posedge clk) disable iff (!rst_n)
        sysclk_en && ctl_wr_en && ctl_wr_kind && ctl_wdata[0] && !irq_pending
        |=> !sysclk_en && !osc_en); // R2
    AST_IRQ_CANCELS: assert property (@(posedge clk) disable iff (!rst_n)
        sysclk_en && ctl_wr_en && irq_pending |=> sysclk_en && !mode_q[0]); // R3
    AST_OTHER_WRITE_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
        sysclk_en && !(ctl_wr_en && ctl_wr_kind) |=> mode_q == $past(mode_q)); // R4
    AST_STOPPED_PADS: assert property (@(posedge clk) disable iff (!rst_n)
        !sysclk_en |-> !strobe_oe && (ad_oe == '0) && (&addr_hi_low)); // R5
    AST_CLAMP_ONLY_STOPPED: assert property (@(posedge clk) disable iff (!rst_n)
        osc_clamp |-> !osc_en && !sysclk_en); // R6
    AST_LEAK_ONLY_STOPPED: assert property (@(posedge clk) disable iff (!rst_n)
        adc_leak |-> !sysclk_en); // R7
    AST_WAKE_RESTORE: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(sysclk_en) |-> osc_en && strobe_oe && (&ad_oe) && (addr_hi_low == '0)); // R8
    AST_WAKE_CLEARS_STP: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(sysclk_en) |-> !mode_q[0]); // R9
    AST_GATED_WRITES_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
        !sysclk_en |=> sysclk_en || (mode_q == $past(mode_q))); // R10
endmodule

bind stby_stop_ctl stby_stop_ctl_chk #(.AD_W(AD_W), .HI_W(HI_W)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .ctl_wr_en   (ctl_wr_en),
    .ctl_wr_kind (ctl_wr_kind),
    .ctl_wdata   (ctl_wdata),
    .irq_pending (irq_pending),
    .mode_q      (mode_q),
    .osc_en      (osc_en),
    .sysclk_en   (sysclk_en),
    .strobe_oe   (strobe_oe),
    .ad_oe       (ad_oe),
    .addr_hi_low (addr_hi_low),
    .osc_clamp   (osc_clamp),
    .adc_leak    (adc_leak)
);

// File: tb/stby_stop_ctl_bench.sv
// Scoreboard bench: the driver pushes expected output vectors after each
// clock edge; the monitor pops and compares them at the following negedge.
module stby_stop_ctl_bench;
    logic        clk = 1'b0;
    logic        rst_n;
    logic        ctl_wr_en, ctl_wr_kind, osc_wr_en, irq_pending, adc_en;
    logic [7:0]  ctl_wdata, osc_wdata, mode_q;
    logic        osc_en, sysclk_en, strobe_oe, osc_clamp, adc_leak;
    logic [7:0]  ad_oe;
    logic [11:0] addr_hi_low;

    typedef struct {
        string       tag;
        logic [32:0] exp;
    } item_t;

    item_t sb_q[$];
    int    n_cmp  = 0;
    int    n_miss = 0;
    int    cycles = 0;
    bit    done   = 0;

    always #2.5 clk = ~clk;  // 200 MHz

    stby_stop_ctl u_stby_stop_ctl (
        .clk(clk), .rst_n(rst_n),
        .ctl_wr_en(ctl_wr_en), .ctl_wr_kind(ctl_wr_kind), .ctl_wdata(ctl_wdata),
        .osc_wr_en(osc_wr_en), .osc_wdata(osc_wdata),
        .irq_pending(irq_pending), .adc_en(adc_en),
        .mode_q(mode_q), .osc_en(osc_en), .sysclk_en(sysclk_en),
        .strobe_oe(strobe_oe), .ad_oe(ad_oe), .addr_hi_low(addr_hi_low),
        .osc_clamp(osc_clamp), .adc_leak(adc_leak)
    );

    // Build an expected vector from per-function values.
    function automatic logic [32:0] ev(bit osc, bit clkg, bit stb, bit ad,
                                       bit hi, bit clmp, bit leak, logic [7:0] m);
        return {osc, clkg, stb, {8{ad}}, {12{hi}}, clmp, leak, m};
    endfunction

    // Advance one edge and queue what the outputs must show afterwards.
    task automatic step(input string tag, input logic [32:0] e);
        item_t it;
        @(posedge clk);
        #1;
        it.tag = tag;
        it.exp = e;
        sb_q.push_back(it);
    endtask

    // Monitor: compare queued expectations away from the active edge.
    always @(negedge clk) begin
        while (sb_q.size() > 0) begin
            item_t it;
            logic [32:0] act;
            it  = sb_q.pop_front();
            act = {osc_en, sysclk_en, strobe_oe, ad_oe, addr_hi_low,
                   osc_clamp, adc_leak, mode_q};
            n_cmp++;
            if (act !== it.exp) begin
                n_miss++;
                $display("FAIL %s: actual %h expected %h", it.tag, act, it.exp);
            end
        end
    end

    // Watchdog: a hung run counts as one failed check.
    always @(posedge clk) begin
        cycles++;
        if (cycles > 5000 && !done) begin
            done = 1;
            n_miss++;
            $display("FAIL watchdog: actual %0d cycles expected under 5000", cycles);
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_miss);
            $finish;
        end
    end

    initial begin
        rst_n = 0; ctl_wr_en = 0; ctl_wr_kind = 0; ctl_wdata = 0;
        osc_wr_en = 0; osc_wdata = 0; irq_pending = 0; adc_en = 0;
        step("R1 in reset", ev(1,1,1,1,0,0,0,8'h00));
        rst_n = 1;
        step("R1 after reset", ev(1,1,1,1,0,0,0,8'h00));

        // R4: non-dedicated access with the stop bit set
        ctl_wr_en = 1; ctl_wr_kind = 0; ctl_wdata = 8'h01;
        step("R4 other access", ev(1,1,1,1,0,0,0,8'h00));
        ctl_wr_en = 0;
        step("R4 still run", ev(1,1,1,1,0,0,0,8'h00));

        // R3: pending interrupt cancels entry, stop bit dropped
        irq_pending = 1; ctl_wr_en = 1; ctl_wr_kind = 1; ctl_wdata = 8'hA5;
        step("R3 cancel", ev(1,1,1,1,0,0,0,8'hA4));
        ctl_wr_en = 0; irq_pending = 0;
        step("R3 stays run", ev(1,1,1,1,0,0,0,8'hA4));

        // Options: internal oscillator, selector 1 -> 8 settle cycles
        osc_wr_en = 1; osc_wdata = 8'h01;
        step("R1 option write", ev(1,1,1,1,0,0,0,8'hA4));
        osc_wr_en = 0;

        // R2 R5 R6 R7: enter stop with converter left enabled
        adc_en = 1; ctl_wr_en = 1; ctl_wr_kind = 1; ctl_wdata = 8'h03;
        step("R2 R5 R6 R7 entry", ev(0,0,0,0,1,1,1,8'h03));
        ctl_wr_en = 0;

        // R10: writes while gated are ignored
        ctl_wr_en = 1; ctl_wdata = 8'h00; osc_wr_en = 1; osc_wdata = 8'h80;
        step("R10 gated writes", ev(0,0,0,0,1,1,1,8'h03));
        ctl_wr_en = 0; osc_wr_en = 0;
        step("R10 after gated writes", ev(0,0,0,0,1,1,1,8'h03));

        // R8: wake, 8 settle cycles, then full restore
        irq_pending = 1;
        step("R8 settle start", ev(1,0,0,0,1,0,1,8'h03));
        irq_pending = 0;
        for (int i = 1; i < 8; i++)
            step("R8 settling", ev(1,0,0,0,1,0,1,8'h03));
        step("R8 R9 restore", ev(1,1,1,1,0,0,0,8'h02));

        // R6: external clock selected -> no clamp; R7 with converter off
        osc_wr_en = 1; osc_wdata = 8'h80;
        step("R6 option ext", ev(1,1,1,1,0,0,0,8'h02));
        osc_wr_en = 0; adc_en = 0;
        ctl_wr_en = 1; ctl_wr_kind = 1; ctl_wdata = 8'h01;
        step("R6 R7 ext entry", ev(0,0,0,0,1,0,0,8'h01));
        ctl_wr_en = 0;

        // R11: reset while stopped
        rst_n = 0;
        step("R11 reset in stop", ev(1,1,1,1,0,0,0,8'h00));
        rst_n = 1;
        step("R11 run", ev(1,1,1,1,0,0,0,8'h00));

        // R11 R6: options cleared by reset -> clamp on; selector 0 -> 4 cycles
        ctl_wr_en = 1; ctl_wr_kind = 1; ctl_wdata = 8'h41;
        step("R11 R6 entry", ev(0,0,0,0,1,1,0,8'h41));
        ctl_wr_en = 0;
        irq_pending = 1;
        step("R8 short settle", ev(1,0,0,0,1,0,0,8'h41));
        irq_pending = 0;
        for (int i = 1; i < 4; i++)
            step("R8 short settling", ev(1,0,0,0,1,0,0,8'h41));
        step("R8 R9 short restore", ev(1,1,1,1,0,0,0,8'h40));
        step("R9 run hold", ev(1,1,1,1,0,0,0,8'h40));

        @(negedge clk);
        #1;
        if (!done) begin
            done = 1;
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_miss);
            $finish;
        end
    end
endmodule